// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds one shift register with the outcomes of the most recent resolved branches, across all addresses. It also holds one shared table of two-bit saturating counters. The table index is the word address of the branch XORed with the global history. A fetch stage presents the branch PC and, in the same cycle, gets a taken / not-taken guess and the table index that produced it.

When the branch resolves, the pipeline returns that index with the real outcome. The block then moves the selected counter toward the outcome, saturating at both ends. It also shifts the outcome into the history. Because the index travels with the branch, history that has changed in the meantime cannot steer the update to a different counter.

The history length `HIST_BITS` sets the table depth at 2^HIST_BITS entries. Storage is HIST_BITS + 2·2^HIST_BITS flops.

Top module: `gshare_predictor`

## Requirements
- R1: `pred_index` equals bits [OFFSET_BITS+HIST_BITS-1 : OFFSET_BITS] of `pred_pc`, with OFFSET_BITS = 2 by default, XORed bitwise with the current global history.
- R2: `pred_taken` is bit 1 (the high bit) of the counter selected by `pred_index`. A value of 1 means taken.
- R3: An update with `upd_taken`=1 raises the selected counter by one. A counter already at 3 (binary 11) stays at 3.
- R4: An update with `upd_taken`=0 lowers the selected counter by one. A counter already at 0 (binary 00) stays at 0.
- R5: An update changes only the counter named by `upd_index`, whatever the current history and `pred_pc` are.
- R6: Each update shifts the history left by one place. `upd_taken` enters bit 0 and the oldest bit is dropped.
- R7: While `upd_valid` is 0, neither the history nor any counter changes.
- R8: After reset, every counter holds 1 (binary 01, weakly not taken) and the history is zero.
- R9: A prediction made in the same cycle as an update sees the state from before that update. The update is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Byte address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | HIST_BITS | Table index used for this prediction |
| upd_valid | input | 1 | Applies an update on this clock edge |
| upd_index | input | HIST_BITS | Index returned from prediction time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The history is only visible through the index. A history bit that is wrong or lost changes `pred_index` for any fixed PC in the very next cycle after the update that caused it. A counter that drifts by one step shows at `pred_taken` only once it crosses the 1/2 boundary. For that reason the bench drives counters into saturation and then walks them back down, so that an error in either direction becomes a wrong prediction within two updates. A reference model follows every cycle, so a wrong entry shows up the next time that index is looked up.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_NT;

    // Saturating step toward the resolved outcome
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_RESET;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_predicts_taken(input ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
    parameter int HIST_BITS   = 8,
    parameter int PC_W        = 32,
    parameter int OFFSET_BITS = 2
) (
    input  logic [PC_W-1:0]      pc,
    input  logic [HIST_BITS-1:0] hist,
    output logic [HIST_BITS-1:0] index
);
    localparam int LSB = OFFSET_BITS;

    logic [HIST_BITS-1:0] word_bits;

    always_comb begin
        word_bits = pc[LSB +: HIST_BITS];
        index     = word_bits ^ hist;
    end
endmodule

// File: rtl/gshare_history.sv
module gshare_history #(
    parameter int HIST_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    output logic [HIST_BITS-1:0] hist_o
);
    typedef struct packed {
        logic [HIST_BITS-1:0] hist;
    } hist_s;

    hist_s st_d, st_q;
    logic [HIST_BITS:0] widened;

    always_comb begin
        st_d    = st_q;
        widened = {st_q.hist, shift_bit};
        if (shift_en) begin
            st_d.hist = widened[HIST_BITS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_o = st_q.hist;

    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.hist));

    assert_hist_newbit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.hist[0] == $past(shift_bit));

    generate
        if (HIST_BITS > 1) begin : g_upper
            assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> st_q.hist[HIST_BITS-1:1] == $past(st_q.hist[HIST_BITS-2:0]));
        end
    endgenerate
endmodule

// File: rtl/gshare_table.sv
module gshare_table
    import gshare_pkg::*;
#(
    parameter int HIST_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HIST_BITS-1:0] rd_index,
    output logic                 rd_taken,
    input  logic                 wr_en,
    input  logic [HIST_BITS-1:0] wr_index,
    input  logic                 wr_taken
);
    localparam int DEPTH = 1 << HIST_BITS;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } tbl_s;

    tbl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_index] = ctr_step(ctr_e'(st_q.ctr[wr_index]), wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctr <= {DEPTH{CTR_RESET}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_taken = ctr_predicts_taken(ctr_e'(st_q.ctr[rd_index]));
    end

    assert_ctr_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q.ctr[wr_index] != 2'b11)
        |=> st_q.ctr[$past(wr_index)] == $past(st_q.ctr[wr_index]) + 2'd1);

    assert_ctr_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q.ctr[wr_index] == 2'b11)
        |=> st_q.ctr[$past(wr_index)] == 2'b11);

    assert_ctr_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q.ctr[wr_index] != 2'b00)
        |=> st_q.ctr[$past(wr_index)] == $past(st_q.ctr[wr_index]) - 2'd1);

    assert_ctr_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q.ctr[wr_index] == 2'b00)
        |=> st_q.ctr[$past(wr_index)] == 2'b00);

    assert_tbl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.ctr));
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
    parameter int HIST_BITS   = 8,
    parameter int PC_W        = 32,
    parameter int OFFSET_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PC_W-1:0]      pred_pc,
    output logic                 pred_taken,
    output logic [HIST_BITS-1:0] pred_index,
    input  logic                 upd_valid,
    input  logic [HIST_BITS-1:0] upd_index,
    input  logic                 upd_taken
);
    logic [HIST_BITS-1:0] hist;

    gshare_history #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist_o    (hist)
    );

    gshare_index #(
        .HIST_BITS   (HIST_BITS),
        .PC_W        (PC_W),
        .OFFSET_BITS (OFFSET_BITS)
    ) u_index (
        .pc    (pred_pc),
        .hist  (hist),
        .index (pred_index)
    );

    gshare_table #(.HIST_BITS(HIST_BITS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_index (pred_index),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_index (upd_index),
        .wr_taken (upd_taken)
    );

    // R1: index with the history cleared must be the raw word-address bits
    assert_index_zero_hist_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hist == '0) |-> pred_index == pred_pc[OFFSET_BITS +: HIST_BITS]);
endmodule

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int K    = 8;
    localparam int PCW  = 32;
    localparam int OFF  = 2;
    localparam int DEP  = 1 << K;

    logic           clk = 0;
    logic           rst_n = 0;
    logic [PCW-1:0] pred_pc = '0;
    logic           pred_taken;
    logic [K-1:0]   pred_index;
    logic           upd_valid = 0;
    logic [K-1:0]   upd_index = '0;
    logic           upd_taken = 0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_ctr [DEP];
    int m_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    gshare_predictor #(.HIST_BITS(K), .PC_W(PCW), .OFFSET_BITS(OFF)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_index(pred_index), .upd_valid(upd_valid), .upd_index(upd_index),
        .upd_taken(upd_taken)
    );

    task automatic model_reset();
        for (int i = 0; i < DEP; i++) m_ctr[i] = 1;
        m_hist = 0;
    endtask

    // Drive at negedge, compare mid-cycle, apply the model update at posedge
    task automatic step(input logic [PCW-1:0] pc, input bit uv, input int ui,
                        input bit ut, input string tag);
        int exp_idx;
        bit exp_tk;
        @(negedge clk);
        pred_pc = pc; upd_valid = uv; upd_index = K'(ui); upd_taken = ut;
        #1;
        exp_idx = ((pc >> OFF) ^ m_hist) % DEP;
        exp_tk  = (m_ctr[exp_idx] >= 2);
        checks++;
        if (int'(pred_index) != exp_idx) begin
            failures++;
            $display("FAIL %s/R1 index: actual=%0d expected=%0d", tag, pred_index, exp_idx);
        end
        checks++;
        if (pred_taken != exp_tk) begin
            failures++;
            $display("FAIL %s/R2 taken: actual=%0d expected=%0d", tag, pred_taken, exp_tk);
        end
        @(posedge clk);
        if (uv) begin
            if (ut) begin if (m_ctr[ui % DEP] < 3) m_ctr[ui % DEP]++; end
            else    begin if (m_ctr[ui % DEP] > 0) m_ctr[ui % DEP]--; end
            m_hist = ((m_hist << 1) | int'(ut)) % DEP;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R8: reset state, every counter weakly not taken, history zero
        for (int i = 0; i < DEP; i++) step(PCW'(i << OFF), 0, 0, 0, "R8");

        // R3: climb index 5 past saturation, then R4 walk down past zero
        for (int i = 0; i < 5; i++) step(PCW'(5 << OFF), 1, 5, 1, "R3");
        step(32'h0, 0, 0, 0, "R6");
        for (int i = 0; i < 5; i++) step(PCW'(5 << OFF), 1, 5, 0, "R4");
        step(32'h0, 0, 0, 0, "R6");

        // R6: history pattern visible through the index with pc = 0
        step(32'h0, 1, 40, 1, "R6");
        step(32'h0, 1, 40, 0, "R6");
        step(32'h0, 1, 40, 1, "R6");
        step(32'h0, 1, 41, 1, "R6");
        step(32'h0, 0, 0, 0, "R6");

        // R5: update index unrelated to the current pc/history
        for (int i = 0; i < 3; i++) step(PCW'(200 << OFF), 1, 77, 1, "R5");
        step(PCW'(77 << OFF), 0, 0, 0, "R5");
        step(PCW'(78 << OFF), 0, 0, 0, "R5");

        // R9: predict the entry being updated in the same cycle
        step(32'h0, 1, 0, 1, "R9");
        step(32'h0, 1, 0, 1, "R9");
        step(32'h0, 0, 0, 0, "R9");

        // R7: idle cycles with noisy update fields
        for (int i = 0; i < 20; i++)
            step(PCW'($urandom), 0, int'($urandom % DEP), bit'($urandom), "R7");

        // Mixed traffic: upper pc bits and offset bits must not matter (R1)
        for (int i = 0; i < 4000; i++) begin
            logic [PCW-1:0] pc;
            pc = PCW'($urandom);
            if (i % 3 == 0) pc = pc & 32'h0000_00FC;
            step(pc, bit'($urandom % 4 != 0), int'($urandom % 16), bit'($urandom % 3 != 0), "R3R4");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule